// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two down-counting interval timers that share a single control word. Each timer owns a slice of that word. The slice sets the reload divisor, chooses between a halted stop-and-load state and a running state, names one of several tick-enable strobes as the counting clock, and carries a one-shot bit that acknowledges the timer's pending interrupt. When a running timer counts down through its last step, it reloads and latches a sticky interrupt flag.

The second timer can count the first timer's underflows instead of an external strobe. Chaining the two this way gives a longer combined period. Software loads the divisors in stop-and-load state, switches to run, and reads either counter at any time. It acknowledges interrupts by rewriting the word with the clear bits set.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both counts read 0, both interrupt flags are 0, and both timers are in stop-and-load state.
- R2: The control word is written when `ctrl_we_i` is high. Each timer i uses bits [i*12 +: 12] of the word: bits [7:0] divisor, bit 8 mode (0 stop-and-load, 1 run), bit 9 interrupt clear (1 clear, 0 no-op), bits [11:10] clock select. While a timer is in stop-and-load state, its count equals its divisor, one cycle after the word is stored.
- R3: In run state, the count drops by one on each cycle in which the selected strobe is high. Strobes that are not selected leave the count unchanged.
- R4: A selected strobe with the count at 1 is an underflow. On an underflow the count reloads from the divisor in the same cycle and the interrupt flag sets. The period is therefore equal to the divisor in ticks, for example 250 ticks at 25 kHz gives 100 Hz. A divisor of 0 gives a 256-tick period: the count goes 0, 255, ..., 1 and then reloads to 0.
- R5: Select values 0 to 2 choose `tick_i[sel]`. Select value 3 chooses `tick_i[3]` for timer 0. For timer 1, select value 3 chooses timer 0's underflow, which is cascade mode.
- R6: An interrupt flag stays set until a control write carries that timer's clear bit. A write with the bit at no-op leaves the flag unchanged.
- R7: If a clear and an underflow of the same timer fall in the same cycle, the flag remains set.
- R8: The clear bit of one timer has no effect on the other timer's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 24 | Control word, one 12-bit slice per timer |
| tick_i | input | 4 | Tick-enable strobes, one per clock source |
| count0_o | output | 8 | Current count of timer 0 |
| count1_o | output | 8 | Current count of timer 1 |
| irq_o | output | 2 | Sticky interrupt flags, bit i for timer i |

## Verification
The bench uses the default build: 8-bit counters and a 2-bit select field. With an 8-bit counter, the 256-tick period that a zero divisor produces can be walked through in full, as can the 250-tick, 100 Hz case. With a 2-bit select field there are exactly four strobes, so every select value, including the cascade value on timer 1, is driven directly. The tests also confirm that the spare strobes cannot move either counter.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int unsigned NUM_TMR = 2;

  typedef enum logic {
    MODE_STOP_LOAD = 1'b0,
    MODE_RUN       = 1'b1
  } dtim_mode_e;
endpackage

// File: rtl/dtim_ctrl.sv
module dtim_ctrl
  import dtim_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   we_i,
  input  logic [NUM_TMR*(CNT_W+2+SEL_W)-1:0]     wdata_i,
  output logic [NUM_TMR-1:0][CNT_W-1:0]          div_o,
  output logic [NUM_TMR-1:0]                     run_o,
  output logic [NUM_TMR-1:0][SEL_W-1:0]          sel_o,
  output logic [NUM_TMR-1:0]                     clr_o
);
  localparam int unsigned SLICE = CNT_W + 2 + SEL_W;
  localparam int unsigned OFS_MODE = CNT_W;
  localparam int unsigned OFS_CLR  = CNT_W + 1;
  localparam int unsigned OFS_SEL  = CNT_W + 2;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_slice
    localparam int unsigned BASE = i * SLICE;
    logic [CNT_W-1:0] div_q;
    dtim_mode_e       mode_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q  <= '0;
        mode_q <= MODE_STOP_LOAD;
        sel_q  <= '0;
      end else if (we_i) begin
        div_q  <= wdata_i[BASE +: CNT_W];
        mode_q <= dtim_mode_e'(wdata_i[BASE + OFS_MODE]);
        sel_q  <= wdata_i[BASE + OFS_SEL +: SEL_W];
      end
    end

    assign div_o[i] = div_q;
    assign run_o[i] = (mode_q == MODE_RUN);
    assign sel_o[i] = sel_q;
    // clear acts only on the write cycle, never stored
    assign clr_o[i] = we_i & wdata_i[BASE + OFS_CLR];

    // R2: a stop-and-load write leaves the timer halted
    a_r2_stop_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !wdata_i[BASE + OFS_MODE]) |=> !run_o[i]);
  end
endmodule

// File: rtl/dtim_chan.sv
module dtim_chan #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_i,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             uf_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  assign uf_o = run_i & step_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= div_i;
    else if (step_i)      cnt_q <= (cnt_q == LAST) ? div_i : cnt_q - LAST;
  end

  // underflow wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (uf_o)   irq_q <= 1'b1;
    else if (clr_i)  irq_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  a_r2_hold_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> count_o == $past(div_i));
  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_i && count_o != LAST) |=> count_o == $past(count_o) - LAST);
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !step_i) |=> $stable(count_o));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |=> (count_o == $past(div_i)) && irq_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !uf_o) |=> !irq_o);
  a_r7_uf_beats_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && uf_o) |=> irq_o);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dtim_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   ctrl_we_i,
  input  logic [NUM_TMR*(CNT_W+2+SEL_W)-1:0]     ctrl_wdata_i,
  input  logic [(1<<SEL_W)-1:0]                  tick_i,
  output logic [CNT_W-1:0]                       count0_o,
  output logic [CNT_W-1:0]                       count1_o,
  output logic [NUM_TMR-1:0]                     irq_o
);
  localparam int unsigned NSRC = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NSRC - 1);

  logic [NUM_TMR-1:0][CNT_W-1:0] div, count;
  logic [NUM_TMR-1:0][SEL_W-1:0] sel;
  logic [NUM_TMR-1:0][NSRC-1:0]  src;
  logic [NUM_TMR-1:0]            run, clr, step, uf;

  dtim_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .div_o   (div),
    .run_o   (run),
    .sel_o   (sel),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    // top select value: own strobe for the first timer, predecessor underflow otherwise
    if (i == 0) begin : g_head
      assign src[i] = tick_i;
    end else begin : g_casc
      assign src[i] = {uf[i-1], tick_i[NSRC-2:0]};
    end
    assign step[i] = src[i][sel[i]];

    dtim_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .div_i   (div[i]),
      .run_i   (run[i]),
      .step_i  (step[i]),
      .clr_i   (clr[i]),
      .count_o (count[i]),
      .uf_o    (uf[i]),
      .irq_o   (irq_o[i])
    );
  end

  assign count0_o = count[0];
  assign count1_o = count[1];

  // R5: cascaded timer steps on every upstream underflow
  a_r5_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run[1] && sel[1] == SEL_TOP && uf[0] && count1_o != CNT_W'(1))
      |=> count1_o == $past(count1_o) - CNT_W'(1));
  // R5: cascaded timer ignores the top external strobe
  a_r5_casc_no_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run[1] && sel[1] == SEL_TOP && !uf[0]) |=> $stable(count1_o));
  // R1: nothing runs straight out of reset
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (irq_o == '0));
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [23:0] ctrl_wdata_i = '0;
  logic [3:0]  tick_i = '0;
  logic [7:0]  count0_o, count1_o;
  logic [1:0]  irq_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_interval_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i), .tick_i(tick_i),
    .count0_o(count0_o), .count1_o(count1_o), .irq_o(irq_o)
  );

  function automatic logic [11:0] sl(int dv, bit run, bit clr, int sel);
    return {2'(sel), clr, run, 8'(dv)};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] s0, logic [11:0] s1);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = {s1, s0};
    @(posedge clk_i);
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic ticks(logic [3:0] m, int n);
    @(negedge clk_i);
    tick_i = m;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
    tick_i = '0;
  endtask

  task automatic t_reset();
    check("R1 count0", count0_o, 0);
    check("R1 count1", count1_o, 0);
    check("R1 irq", irq_o, 0);
    ticks(4'hf, 3);
    check("R1 halted", count0_o, 0);
  endtask

  task automatic t_stop_load();
    wr(sl(5, 0, 1, 0), sl(9, 0, 1, 0));
    @(negedge clk_i);
    check("R2 load0", count0_o, 5);
    check("R2 load1", count1_o, 9);
    ticks(4'hf, 4);
    check("R2 halted", count0_o, 5);
  endtask

  task automatic t_run_select();
    wr(sl(5, 1, 0, 1), sl(9, 0, 0, 0));
    ticks(4'b1101, 3);
    check("R3 unselected", count0_o, 5);
    ticks(4'b0010, 1);
    check("R3 step", count0_o, 4);
    ticks(4'b0010, 3);
    check("R3 at one", count0_o, 1);
    check("R4 no irq yet", irq_o[0], 0);
    ticks(4'b0010, 1);
    check("R4 reload", count0_o, 5);
    check("R4 irq set", irq_o[0], 1);
    wr(sl(7, 0, 0, 3), sl(9, 0, 0, 0));
    wr(sl(7, 1, 0, 3), sl(9, 0, 0, 0));
    ticks(4'b1000, 1);
    check("R5 t0 sel3", count0_o, 6);
  endtask

  task automatic t_clear();
    wr(sl(7, 1, 0, 3), sl(9, 0, 0, 0));
    check("R6 nop keeps", irq_o[0], 1);
    wr(sl(7, 1, 1, 3), sl(9, 0, 0, 0));
    check("R6 cleared", irq_o[0], 0);
  endtask

  task automatic t_collision();
    wr(sl(3, 0, 1, 0), sl(9, 0, 1, 0));
    wr(sl(3, 1, 0, 0), sl(9, 0, 0, 0));
    ticks(4'b0001, 2);
    check("R7 at one", count0_o, 1);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = {sl(9, 0, 0, 0), sl(3, 1, 1, 0)};
    tick_i = 4'b0001;
    @(posedge clk_i);
    @(negedge clk_i);
    ctrl_we_i = 1'b0; tick_i = '0;
    check("R7 flag kept", irq_o[0], 1);
    check("R7 reload", count0_o, 3);
    wr(sl(3, 1, 1, 0), sl(9, 0, 0, 0));
    check("R6 later clear", irq_o[0], 0);
  endtask

  task automatic t_cascade();
    wr(sl(2, 0, 1, 0), sl(3, 0, 1, 3));
    wr(sl(2, 1, 0, 0), sl(3, 1, 0, 3));
    ticks(4'b0001, 2);
    check("R5 casc first", count1_o, 2);
    ticks(4'b1000, 2);
    check("R5 casc ext ignored", count1_o, 2);
    ticks(4'b0001, 2);
    check("R5 casc second", count1_o, 1);
    check("R5 no irq1 yet", irq_o[1], 0);
    ticks(4'b0001, 2);
    check("R5 casc wrap", count1_o, 3);
    check("R5 irq1", irq_o[1], 1);
    wr(sl(2, 0, 1, 0), sl(3, 0, 0, 3));
    check("R8 own cleared", irq_o[0], 0);
    check("R8 other kept", irq_o[1], 1);
  endtask

  task automatic t_div_zero();
    wr(sl(0, 0, 1, 0), sl(0, 0, 1, 0));
    wr(sl(0, 1, 0, 0), sl(0, 0, 0, 0));
    check("R4 zero load", count0_o, 0);
    ticks(4'b0001, 1);
    check("R4 zero wrap", count0_o, 255);
    ticks(4'b0001, 254);
    check("R4 zero at one", count0_o, 1);
    check("R4 zero no irq", irq_o[0], 0);
    ticks(4'b0001, 1);
    check("R4 zero reload", count0_o, 0);
    check("R4 zero irq", irq_o[0], 1);
  endtask

  task automatic t_hundred_hz();
    wr(sl(250, 0, 1, 0), sl(0, 0, 0, 0));
    wr(sl(250, 1, 0, 0), sl(0, 0, 0, 0));
    ticks(4'b0001, 249);
    check("R4 250 early", irq_o[0], 0);
    ticks(4'b0001, 1);
    check("R4 250 irq", irq_o[0], 1);
    check("R4 250 reload", count0_o, 250);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_stop_load();
    t_run_select();
    t_clear();
    t_collision();
    t_cascade();
    t_div_zero();
    t_hundred_hz();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule